// File: doc/BRIEF.md
# Flash Command Interface Front End

This block sits between the asynchronous, active-low strobes of a byte-wide, block-erasable flash memory bus and the synchronous logic behind it. The three strobes (chip enable, write enable, output enable) pass through a two-flop synchronizer. Rising edges are then found in the clock domain. A bus write is recognised while chip enable and write enable are both low and output enable is high. The address and data of the write are held from the last sampled cycle before the first strobe rises. It does not matter which strobe rises first.

Each captured byte is decoded as a command. One command enters identifier mode and another returns to array mode. Erase, program and lock-configuration commands are passed on as a one-cycle request, but only while the programming-voltage flag says the supply is above lockout. In array mode, read data comes from an external read port that is driven by the bus address. In identifier mode, read data comes from a sparse map: the manufacturer code, the device code, the master lock byte, and one lock byte at offset 2 of every 64 KB block. Every other address reads back a fixed reserved value. The lock bits are loaded through a side port.

The write path is a four-state machine. In WS_IDLE it waits for both strobes to go low with output enable high, and then moves to WS_ACTIVE. In WS_ACTIVE it keeps loading the bus values. It moves to WS_DONE on the first rising strobe, or to WS_RECOVER if output enable drops. WS_DONE lasts one cycle and issues the capture strobe. It then goes to WS_IDLE if both strobes are already high, or to WS_RECOVER otherwise. WS_RECOVER goes back to WS_IDLE once both strobes are high. The read mode is a two-state machine. RM_ARRAY goes to RM_IDENT on command 0x90, and RM_IDENT goes to RM_ARRAY on command 0xFF.

Top module: `flash_cmd_front`

## Requirements
- R1: After reset the read mode is array, `dout_en` and `dout` are 0, and `mod_stb` is 0.
- R2: A write is captured only while `ce_n` and `we_n` are both low and `oe_n` is high. A cycle with `oe_n` low or `ce_n` high is not a write and leaves the mode unchanged.
- R3: The captured address and data are the bus values present before the first of `we_n` or `ce_n` rises. Bus changes after that edge and before the second strobe rises have no effect.
- R4: Command byte 0x90 selects identifier mode and 0xFF selects array mode. Any other byte leaves the mode unchanged.
- R5: In identifier mode, address 0x000000 reads `MFR_CODE` (default 0xA7) and address 0x000001 reads `DEV_CODE` (default 0x3C).
- R6: In identifier mode, address 0x000003 reads the master lock bit in bit 0, with the other bits 0.
- R7: In identifier mode, address k×0x10000+2 reads the lock bit of block k in bit 0, with the other bits 0. There are 32 blocks at the default width.
- R8: Every other identifier-mode address reads `RSVD_CODE` (default 0x00). This includes offset 3 of any block other than 0.
- R9: In array mode, `arr_addr` follows `addr` and the read data equals `arr_data`.
- R10: `dout_en` is high, and `dout` carries read data, only while the synchronized `ce_n` and `oe_n` are low and `we_n` is high. Otherwise both are 0.
- R11: Commands 0x20, 0x40, 0x10 and 0x60 raise `mod_stb` for exactly one cycle, with `mod_cmd` and `mod_addr`, only if `prog_volt_ok` is high. With `prog_volt_ok` low no strobe is issued. These commands never change the read mode.
- R12: A `lock_load` pulse copies `lock_in` (bit k is block k) and `master_in` into the lock registers, replacing the previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip enable, active low, asynchronous |
| we_n | input | 1 | Write enable, active low, asynchronous |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| addr | input | ADDR_W | Bus address |
| din | input | DATA_W | Bus write data |
| dout | output | DATA_W | Read data, 0 when not driven |
| dout_en | output | 1 | Read data valid / output drive enable |
| prog_volt_ok | input | 1 | High when the programming supply is above lockout |
| lock_load | input | 1 | Load strobe for the lock registers |
| lock_in | input | NUM_BLOCKS | Per-block lock bits to load |
| master_in | input | 1 | Master lock bit to load |
| arr_addr | output | ADDR_W | Array read address |
| arr_data | input | DATA_W | Array read data |
| mod_stb | output | 1 | One-cycle modify-command request |
| mod_cmd | output | DATA_W | Command byte of the request |
| mod_addr | output | ADDR_W | Address captured with the request |

## Verification
Writes are applied in both strobe orders: write enable first and chip enable first. In each order the address and data change between the two rising strobes, which separates first-edge capture from last-edge capture. Writes with output enable low and writes with chip enable high are also applied, and read-backs show whether the mode moved. Identifier reads cover the fixed codes, lock offsets in low, middle and top blocks, offset 3 outside block 0, and reserved holes, which tells the sparse decode apart from a plain address slice. Modify commands are sent with the voltage flag low and high, and a strobe scoreboard expects requests only in the second case.

// File: rtl/flash_fe_pkg.sv
package flash_fe_pkg;

    typedef enum logic [1:0] {
        WS_IDLE,
        WS_ACTIVE,
        WS_DONE,
        WS_RECOVER
    } wr_state_t;

    typedef enum logic {
        RM_ARRAY,
        RM_IDENT
    } rd_mode_t;

    localparam logic [7:0] CMD_IDENT    = 8'h90;
    localparam logic [7:0] CMD_ARRAY    = 8'hFF;
    localparam logic [7:0] CMD_ERASE    = 8'h20;
    localparam logic [7:0] CMD_PROG     = 8'h40;
    localparam logic [7:0] CMD_PROG_ALT = 8'h10;
    localparam logic [7:0] CMD_LOCKCFG  = 8'h60;

    function automatic logic is_modify(input logic [7:0] code);
        return (code == CMD_ERASE) || (code == CMD_PROG) ||
               (code == CMD_PROG_ALT) || (code == CMD_LOCKCFG);
    endfunction

endpackage

// File: rtl/fe_strobe_sync.sv
module fe_strobe_sync #(
    parameter int N      = 3,
    parameter int N_EDGE = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N-1:0]      raw_n,
    output logic [N-1:0]      lvl_n,
    output logic [N_EDGE-1:0] rise
);

    logic [N-1:0] stage1;
    logic [N-1:0] stage2;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= '1;
            stage2 <= '1;
        end else begin
            stage1 <= raw_n;
            stage2 <= stage1;
        end
    end

    assign lvl_n = stage2;

    for (genvar g = 0; g < N_EDGE; g++) begin : g_edge
        logic prev_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prev_q <= 1'b1;
            else        prev_q <= stage2[g];
        end
        assign rise[g] = stage2[g] & ~prev_q;
    end

endmodule

// File: rtl/fe_write_fsm.sv
module fe_write_fsm
    import flash_fe_pkg::*;
#(
    parameter int ADDR_W = 21,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_l,
    input  logic              we_l,
    input  logic              oe_l,
    input  logic              ce_rise,
    input  logic              we_rise,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] data_in,
    output logic              wr_stb,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);

    wr_state_t state_q, state_d;
    logic      bus_wr;
    logic      load_hold;

    assign bus_wr = !ce_l && !we_l && oe_l;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= WS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WS_IDLE:    if (bus_wr) state_d = WS_ACTIVE;
            WS_ACTIVE: begin
                if (we_rise || ce_rise) state_d = WS_DONE;
                else if (!oe_l)         state_d = WS_RECOVER;
            end
            WS_DONE:    state_d = (ce_l && we_l) ? WS_IDLE : WS_RECOVER;
            WS_RECOVER: if (ce_l && we_l) state_d = WS_IDLE;
            default:    state_d = WS_IDLE;
        endcase
    end

    always_comb begin
        wr_stb    = (state_q == WS_DONE);
        load_hold = bus_wr && ((state_q == WS_IDLE) || (state_q == WS_ACTIVE));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_addr <= '0;
            wr_data <= '0;
        end else if (load_hold) begin
            wr_addr <= addr_in;
            wr_data <= data_in;
        end
    end

endmodule

// File: rtl/fe_id_decode.sv
module fe_id_decode #(
    parameter int          ADDR_W     = 21,
    parameter int          DATA_W     = 8,
    parameter int          BLK_SHIFT  = 16,
    parameter int          NUM_BLOCKS = 32,
    parameter logic [7:0]  MFR_CODE   = 8'hA7,
    parameter logic [7:0]  DEV_CODE   = 8'h3C,
    parameter logic [7:0]  RSVD_CODE  = 8'h00
) (
    input  logic [ADDR_W-1:0]     addr,
    input  logic [NUM_BLOCKS-1:0] lock_bits,
    input  logic                  master_bit,
    output logic [DATA_W-1:0]     id_byte
);

    localparam int BLK_W = ADDR_W - BLK_SHIFT;

    logic [BLK_SHIFT-1:0] offset;
    logic [BLK_W-1:0]     blk;

    assign offset = addr[BLK_SHIFT-1:0];
    assign blk    = addr[ADDR_W-1:BLK_SHIFT];

    always_comb begin
        id_byte = DATA_W'(RSVD_CODE);
        if (offset == BLK_SHIFT'(2)) begin
            id_byte = DATA_W'(lock_bits[blk]);
        end else if (blk == '0) begin
            if (offset == BLK_SHIFT'(0))      id_byte = DATA_W'(MFR_CODE);
            else if (offset == BLK_SHIFT'(1)) id_byte = DATA_W'(DEV_CODE);
            else if (offset == BLK_SHIFT'(3)) id_byte = DATA_W'(master_bit);
        end
    end

endmodule

// File: rtl/flash_cmd_front.sv
module flash_cmd_front
    import flash_fe_pkg::*;
#(
    parameter int         ADDR_W     = 21,
    parameter int         DATA_W     = 8,
    parameter int         BLK_SHIFT  = 16,
    parameter int         NUM_BLOCKS = 2 ** (ADDR_W - BLK_SHIFT),
    parameter logic [7:0] MFR_CODE   = 8'hA7,
    parameter logic [7:0] DEV_CODE   = 8'h3C,
    parameter logic [7:0] RSVD_CODE  = 8'h00
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ce_n,
    input  logic                  we_n,
    input  logic                  oe_n,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [DATA_W-1:0]     din,
    output logic [DATA_W-1:0]     dout,
    output logic                  dout_en,
    input  logic                  prog_volt_ok,
    input  logic                  lock_load,
    input  logic [NUM_BLOCKS-1:0] lock_in,
    input  logic                  master_in,
    output logic [ADDR_W-1:0]     arr_addr,
    input  logic [DATA_W-1:0]     arr_data,
    output logic                  mod_stb,
    output logic [DATA_W-1:0]     mod_cmd,
    output logic [ADDR_W-1:0]     mod_addr
);

    localparam int SYNC_STAGES = 2;

    // strobe synchronisation: bit0 = we, bit1 = ce, bit2 = oe
    logic [2:0] strb_lvl;
    logic [1:0] strb_rise;

    fe_strobe_sync #(.N(3), .N_EDGE(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .raw_n ({oe_n, ce_n, we_n}),
        .lvl_n (strb_lvl),
        .rise  (strb_rise)
    );

    // bus value delay matched to the strobe synchroniser
    logic [ADDR_W-1:0] addr_dly [SYNC_STAGES];
    logic [DATA_W-1:0] data_dly [SYNC_STAGES];

    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_dly
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                addr_dly[s] <= '0;
                data_dly[s] <= '0;
            end else if (s == 0) begin
                addr_dly[s] <= addr;
                data_dly[s] <= din;
            end else begin
                addr_dly[s] <= addr_dly[s-1];
                data_dly[s] <= data_dly[s-1];
            end
        end
    end

    logic              wr_stb;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;

    fe_write_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wr (
        .clk     (clk),
        .rst_n   (rst_n),
        .ce_l    (strb_lvl[1]),
        .we_l    (strb_lvl[0]),
        .oe_l    (strb_lvl[2]),
        .ce_rise (strb_rise[1]),
        .we_rise (strb_rise[0]),
        .addr_in (addr_dly[SYNC_STAGES-1]),
        .data_in (data_dly[SYNC_STAGES-1]),
        .wr_stb  (wr_stb),
        .wr_addr (wr_addr),
        .wr_data (wr_data)
    );

    // read mode state machine
    rd_mode_t mode_q, mode_d;
    logic     ident_mode;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= RM_ARRAY;
        else        mode_q <= mode_d;
    end

    always_comb begin
        mode_d = mode_q;
        if (wr_stb) begin
            unique case (mode_q)
                RM_ARRAY: if (wr_data == DATA_W'(CMD_IDENT)) mode_d = RM_IDENT;
                RM_IDENT: if (wr_data == DATA_W'(CMD_ARRAY)) mode_d = RM_ARRAY;
                default:  mode_d = RM_ARRAY;
            endcase
        end
    end

    assign ident_mode = (mode_q == RM_IDENT);

    // modify-command request, gated by programming voltage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mod_stb  <= 1'b0;
            mod_cmd  <= '0;
            mod_addr <= '0;
        end else begin
            mod_stb <= wr_stb && is_modify(8'(wr_data)) && prog_volt_ok;
            if (wr_stb) begin
                mod_cmd  <= wr_data;
                mod_addr <= wr_addr;
            end
        end
    end

    // lock registers
    logic [NUM_BLOCKS-1:0] lock_q;
    logic                  master_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lock_q   <= '0;
            master_q <= 1'b0;
        end else if (lock_load) begin
            lock_q   <= lock_in;
            master_q <= master_in;
        end
    end

    logic [DATA_W-1:0] id_byte;

    fe_id_decode #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .BLK_SHIFT  (BLK_SHIFT),
        .NUM_BLOCKS (NUM_BLOCKS),
        .MFR_CODE   (MFR_CODE),
        .DEV_CODE   (DEV_CODE),
        .RSVD_CODE  (RSVD_CODE)
    ) u_id (
        .addr       (addr),
        .lock_bits  (lock_q),
        .master_bit (master_q),
        .id_byte    (id_byte)
    );

    // read output
    logic read_on;
    assign read_on  = !strb_lvl[1] && !strb_lvl[2] && strb_lvl[0];
    assign arr_addr = addr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout_en <= 1'b0;
            dout    <= '0;
        end else begin
            dout_en <= read_on;
            dout    <= read_on ? (ident_mode ? id_byte : arr_data) : '0;
        end
    end

endmodule

// File: rtl/fe_checker.sv
module fe_checker (
    input logic clk,
    input logic rst_n,
    input logic ce_n,
    input logic we_n,
    input logic oe_n,
    input logic prog_volt_ok,
    input logic dout_en,
    input logic mod_stb,
    input logic wr_stb,
    input logic ident_mode
);

    AST_MOD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        mod_stb |=> !mod_stb); // R11

    AST_MOD_NEEDS_VOLT: assert property (@(posedge clk) disable iff (!rst_n)
        mod_stb |-> $past(prog_volt_ok)); // R11

    AST_DRIVE_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        dout_en |-> ($past(ce_n, 3) == 1'b0 && $past(oe_n, 3) == 1'b0 && $past(we_n, 3) == 1'b1)); // R10

    AST_MODE_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (ident_mode != $past(ident_mode)) |-> $past(wr_stb)); // R4

    AST_CAPTURE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb); // R3

endmodule

bind flash_cmd_front fe_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ce_n         (ce_n),
    .we_n         (we_n),
    .oe_n         (oe_n),
    .prog_volt_ok (prog_volt_ok),
    .dout_en      (dout_en),
    .mod_stb      (mod_stb),
    .wr_stb       (wr_stb),
    .ident_mode   (ident_mode)
);

// File: tb/sim_flash_cmd_front.sv
`timescale 1ns/1ps
module sim_flash_cmd_front;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [20:0] addr = '0;
    logic [7:0]  din = '0;
    logic [7:0]  dout;
    logic        dout_en;
    logic        prog_volt_ok = 1'b0;
    logic        lock_load = 1'b0;
    logic [31:0] lock_in = '0;
    logic        master_in = 1'b0;
    logic [20:0] arr_addr;
    logic [7:0]  arr_data;
    logic        mod_stb;
    logic [7:0]  mod_cmd;
    logic [20:0] mod_addr;

    always #2.5 clk = ~clk;

    assign arr_data = arr_addr[7:0] ^ 8'h5A;

    flash_cmd_front u0 (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .din(din), .dout(dout), .dout_en(dout_en),
        .prog_volt_ok(prog_volt_ok), .lock_load(lock_load), .lock_in(lock_in),
        .master_in(master_in), .arr_addr(arr_addr), .arr_data(arr_data),
        .mod_stb(mod_stb), .mod_cmd(mod_cmd), .mod_addr(mod_addr)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;
    logic smp = 1'b0;

    logic [7:0]  rd_q[$];
    string       rd_tag_q[$];
    logic [28:0] mod_q[$];
    string       mod_tag_q[$];

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // monitor: read results
    always @(negedge clk) begin
        if (smp) begin
            logic [7:0] e;
            string t;
            e = rd_q.pop_front();
            t = rd_tag_q.pop_front();
            check(dout_en === 1'b1 && dout === e, t, {23'b0, dout_en, dout}, {24'h1, e});
        end
    end

    // monitor: modify requests
    always @(negedge clk) begin
        if (rst_n && mod_stb === 1'b1) begin
            if (mod_q.size() == 0) begin
                check(1'b0, "R11 unexpected mod_stb", {3'b0, mod_cmd, mod_addr}, 32'h0);
            end else begin
                logic [28:0] e;
                string t;
                e = mod_q.pop_front();
                t = mod_tag_q.pop_front();
                check({mod_cmd, mod_addr} === e, t, {3'b0, mod_cmd, mod_addr}, {3'b0, e});
            end
        end
    end

    task automatic bus_read(input logic [20:0] a, input logic [7:0] e, input string t);
        rd_q.push_back(e);
        rd_tag_q.push_back(t);
        addr = a; we_n = 1'b1; ce_n = 1'b0; oe_n = 1'b0;
        repeat (6) @(posedge clk);
        #1 smp = 1'b1;
        @(posedge clk);
        #1 smp = 1'b0; ce_n = 1'b1; oe_n = 1'b1;
        repeat (4) @(posedge clk);
        #1;
    endtask

    // generic write: first strobe rises, bus changes to (a2,d2), then second strobe rises
    task automatic bus_write(input logic [20:0] a, input logic [7:0] d, input bit ce_first,
                             input bit oe_low, input bit ce_off,
                             input logic [20:0] a2, input logic [7:0] d2);
        addr = a; din = d; oe_n = oe_low ? 1'b0 : 1'b1;
        ce_n = ce_off ? 1'b1 : 1'b0; we_n = 1'b0;
        repeat (4) @(posedge clk);
        #1;
        if (ce_first) ce_n = 1'b1; else we_n = 1'b1;
        @(posedge clk);
        #1 addr = a2; din = d2;
        repeat (3) @(posedge clk);
        #1 ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        repeat (8) @(posedge clk);
        #1;
    endtask

    task automatic expect_mod(input logic [7:0] c, input logic [20:0] a, input string t);
        mod_q.push_back({c, a});
        mod_tag_q.push_back(t);
    endtask

    task automatic load_locks(input logic [31:0] l, input logic m);
        lock_in = l; master_in = m;
        @(posedge clk); #1 lock_load = 1'b1;
        @(posedge clk); #1 lock_load = 1'b0;
        @(posedge clk); #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(dout_en === 1'b0 && dout === 8'h00, "R1 reset outputs", {23'b0, dout_en, dout}, 32'h0);
        check(mod_stb === 1'b0, "R1 reset mod_stb", {31'b0, mod_stb}, 32'h0);
        @(posedge clk); #1;

        bus_read(21'h000000, 8'h00 ^ 8'h5A, "R1 array mode after reset");
        load_locks(32'h8000_8083, 1'b1);
        bus_read(21'h012345, 8'h45 ^ 8'h5A, "R9 array read");

        // R2: not a write when output enable low, or when chip enable high
        bus_write(21'h0, 8'h90, 1'b0, 1'b1, 1'b0, 21'h0, 8'h90);
        bus_read(21'h000000, 8'h5A, "R2 oe low ignored");
        bus_write(21'h0, 8'h90, 1'b0, 1'b0, 1'b1, 21'h0, 8'h90);
        bus_read(21'h000001, 8'h01 ^ 8'h5A, "R2 ce high ignored");

        // R3 we-first: data changes to 0xFF between edges, must still enter ident
        bus_write(21'h1ABCDE, 8'h90, 1'b0, 1'b0, 1'b0, 21'h000000, 8'hFF);
        bus_read(21'h000000, 8'hA7, "R3 R5 we-first capture, mfr code");
        bus_read(21'h000001, 8'h3C, "R5 device code");
        bus_read(21'h000003, 8'h01, "R6 master lock");
        bus_read(21'h000002, 8'h01, "R7 block 0 lock");
        bus_read(21'h010002, 8'h01, "R7 block 1 lock");
        bus_read(21'h020002, 8'h00, "R7 block 2 unlocked");
        bus_read(21'h070002, 8'h01, "R7 block 7 lock");
        bus_read(21'h0F0002, 8'h01, "R7 block 15 lock");
        bus_read(21'h1F0002, 8'h01, "R7 block 31 lock");
        bus_read(21'h000004, 8'h00, "R8 reserved block 0");
        bus_read(21'h010003, 8'h00, "R8 offset 3 outside block 0");
        bus_read(21'h0F0000, 8'h00, "R8 reserved block 15 base");
        bus_read(21'h1FFFFF, 8'h00, "R8 reserved top");

        // R4: unknown command keeps ident
        bus_write(21'h000100, 8'h33, 1'b0, 1'b0, 1'b0, 21'h000100, 8'h33);
        bus_read(21'h000000, 8'hA7, "R4 unknown keeps ident");

        // R11 lockout: erase suppressed, mode unchanged
        prog_volt_ok = 1'b0;
        bus_write(21'h050000, 8'h20, 1'b0, 1'b0, 1'b0, 21'h050000, 8'h20);
        bus_read(21'h000001, 8'h3C, "R11 lockout keeps mode");

        // R3 ce-first: 0xFF captured, later 0x90 ignored
        bus_write(21'h000000, 8'hFF, 1'b1, 1'b0, 1'b0, 21'h000000, 8'h90);
        bus_read(21'h000003, 8'h03 ^ 8'h5A, "R3 R4 ce-first capture, array");

        // R11 with voltage: ce-first, address changes after first edge
        prog_volt_ok = 1'b1;
        expect_mod(8'h40, 21'h0A1234, "R11 R3 program request");
        bus_write(21'h0A1234, 8'h40, 1'b1, 1'b0, 1'b0, 21'h155555, 8'h90);
        expect_mod(8'h60, 21'h000007, "R11 lock cfg request");
        bus_write(21'h000007, 8'h60, 1'b0, 1'b0, 1'b0, 21'h000007, 8'h60);
        expect_mod(8'h10, 21'h1F0000, "R11 alt program request");
        bus_write(21'h1F0000, 8'h10, 1'b0, 1'b0, 1'b0, 21'h1F0000, 8'h10);
        bus_read(21'h0000AB, 8'hAB ^ 8'h5A, "R11 modify keeps array");

        // R10: no drive during write strobe or with oe high
        addr = 21'h0; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b0;
        repeat (6) @(posedge clk);
        @(negedge clk);
        check(dout_en === 1'b0 && dout === 8'h00, "R10 no drive with we low", {23'b0, dout_en, dout}, 32'h0);
        #1 we_n = 1'b1; oe_n = 1'b1;
        repeat (6) @(posedge clk);
        @(negedge clk);
        check(dout_en === 1'b0 && dout === 8'h00, "R10 no drive with oe high", {23'b0, dout_en, dout}, 32'h0);
        #1 ce_n = 1'b1;
        repeat (4) @(posedge clk); #1;

        // R12 reload
        bus_write(21'h000000, 8'h90, 1'b0, 1'b0, 1'b0, 21'h000000, 8'h90);
        load_locks(32'h0000_0002, 1'b0);
        bus_read(21'h000002, 8'h00, "R12 block 0 cleared");
        bus_read(21'h010002, 8'h01, "R12 block 1 set");
        bus_read(21'h000003, 8'h00, "R12 master cleared");

        repeat (10) @(posedge clk);
        check(mod_q.size() == 0, "R11 all requests seen", mod_q.size(), 32'h0);
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule